// File: doc/BRIEF.md
# Sliding-Window Byte SAD Unit

This block is a pipelined 128-bit datapath for block matching. One 32-bit group of four unsigned reference bytes is compared against eight overlapping four-byte windows. The windows are taken from a second 128-bit vector. For each window the block adds up the four absolute byte differences. The eight sums are returned as 16-bit words packed into one 128-bit result, and that result takes the place of the window operand.

An 8-bit control byte sets up each operation:
- Its two low bits pick which of the four reference groups is used.
- Its third bit moves the window base from byte 0 to byte 4 of the window vector.
- Each successive output slides its window one byte higher.

Operands arrive with a valid strobe. The result comes out with its own valid strobe exactly two clock cycles later. A new operation can be accepted on every cycle.

Top module: `sad_multi_offset`

## Requirements
- R1: Control bits [1:0] hold a value k from 0 to 3. The reference bytes for the operation are bytes 4k, 4k+1, 4k+2 and 4k+3 of the reference vector, where byte n is bits [8n+7:8n].
- R2: Control bit [2] selects the window base b. When the bit is 0, b is byte 0 of the window vector. When the bit is 1, b is byte 4.
- R3: Output sum j (j = 0..7) pairs window bytes b+j, b+j+1, b+j+2 and b+j+3 with reference bytes 0, 1, 2 and 3 in that order.
- R4: Each term is the unsigned absolute difference of two 8-bit values, and it is the same whichever operand is larger. The four terms of a window are added.
- R5: Sum j appears at result bits [16j+15:16j]. A sum never exceeds 1020, so bits [16j+15:16j+10] of every word are zero.
- R6: Control bits [7:3] have no effect on the result.
- R7: Byte 15 of the window vector never affects the result, for any control value.
- R8: Output valid is high exactly two cycles after input valid was high, and low otherwise. Operations presented on consecutive cycles each produce their own correct result, in order.
- R9: The reset is synchronous and active high. It clears the valid pipeline, so output valid is low on the cycle after reset is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands and control byte are valid this cycle |
| windowVec | input | 128 | Window (destination) operand, byte n at bits [8n+7:8n] |
| refVec | input | 128 | Reference operand |
| ctrlByte | input | 8 | Control: [1:0] reference group, [2] window base, [7:3] unused |
| outValid | output | 1 | Result valid |
| resultVec | output | 128 | Eight packed 16-bit sums |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, four-byte groups, eight sums of 16 bits and a 128-bit vector. These values are the only ones the packing rule fits. With them, all eight control values can be reached with all four reference groups and both window bases, including the base-4 case where the last window ends at byte 14. Extreme byte values (0 against 255) push every sum to its 1020 ceiling, which exercises the zero upper bits of each word. Back-to-back issue tests the two-stage pipeline at full throughput.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int BYTE_W      = 8;
  localparam int GROUP_BYTES = 4;
  localparam int NUM_SUMS    = 8;
  localparam int SUM_W       = 16;
  localparam int VEC_W       = 128;
  localparam int CTRL_W      = 8;
  localparam int NUM_GROUPS  = VEC_W / (GROUP_BYTES * BYTE_W);
  localparam int REF_SEL_W   = $clog2(NUM_GROUPS);
  localparam int BASE_BIT    = REF_SEL_W;

  typedef struct packed {
    logic                 loadDiff;
    logic                 loadSum;
    logic [REF_SEL_W-1:0] refSel;
    logic                 baseHigh;
  } ctrlStrobes_t;
endpackage

// File: rtl/sad_ctrl.sv
module sad_ctrl
  import sad_pkg::*;
#(
  parameter int CTRL_BITS = CTRL_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic [CTRL_BITS-1:0] ctrlByte,
  output ctrlStrobes_t         strobes,
  output logic                 outValid
);
  logic validStage1;
  logic validStage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      validStage1 <= 1'b0;
      validStage2 <= 1'b0;
    end else begin
      validStage1 <= inValid;
      validStage2 <= validStage1;
    end
  end

  // Only the group-select and base bits are decoded; the rest are dropped.
  always_comb begin
    strobes.loadDiff = inValid;
    strobes.loadSum  = validStage1;
    strobes.refSel   = ctrlByte[REF_SEL_W-1:0];
    strobes.baseHigh = ctrlByte[BASE_BIT];
  end

  assign outValid = validStage2;
endmodule

// File: rtl/sad_datapath.sv
module sad_datapath
  import sad_pkg::*;
#(
  parameter int BYTE_BITS  = BYTE_W,
  parameter int GRP_BYTES  = GROUP_BYTES,
  parameter int SUMS       = NUM_SUMS,
  parameter int WORD_BITS  = SUM_W,
  parameter int VEC_BITS   = VEC_W
) (
  input  logic                clk,
  input  ctrlStrobes_t        strobes,
  input  logic [VEC_BITS-1:0] windowVec,
  input  logic [VEC_BITS-1:0] refVec,
  output logic [VEC_BITS-1:0] resultVec
);
  localparam int GROUPS    = VEC_BITS / (GRP_BYTES * BYTE_BITS);
  localparam int BASE_STEP = GRP_BYTES;

  logic [BYTE_BITS-1:0] refGroups [GROUPS][GRP_BYTES];
  logic [BYTE_BITS-1:0] refByte   [GRP_BYTES];
  logic [BYTE_BITS-1:0] winByte   [SUMS][GRP_BYTES];
  logic [BYTE_BITS-1:0] diffComb  [SUMS][GRP_BYTES];
  logic [BYTE_BITS-1:0] diffReg   [SUMS][GRP_BYTES];
  logic [WORD_BITS-1:0] sumComb   [SUMS];
  logic [WORD_BITS-1:0] sumReg    [SUMS];

  // Split the reference vector into its selectable groups.
  for (genvar g = 0; g < GROUPS; g++) begin : g_refGroup
    for (genvar i = 0; i < GRP_BYTES; i++) begin : g_refByte
      assign refGroups[g][i] = refVec[(g*GRP_BYTES+i)*BYTE_BITS +: BYTE_BITS];
    end
  end

  for (genvar i = 0; i < GRP_BYTES; i++) begin : g_refSel
    assign refByte[i] = refGroups[strobes.refSel][i];
  end

  // Each window is a fixed two-way mux between the low and high base.
  for (genvar j = 0; j < SUMS; j++) begin : g_win
    for (genvar i = 0; i < GRP_BYTES; i++) begin : g_term
      assign winByte[j][i] = strobes.baseHigh
        ? windowVec[(BASE_STEP+j+i)*BYTE_BITS +: BYTE_BITS]
        : windowVec[(j+i)*BYTE_BITS +: BYTE_BITS];
      assign diffComb[j][i] = (winByte[j][i] >= refByte[i])
        ? winByte[j][i] - refByte[i]
        : refByte[i] - winByte[j][i];

      always_ff @(posedge clk) begin
        if (strobes.loadDiff) diffReg[j][i] <= diffComb[j][i];
      end
    end
  end

  // Second stage: reduce four registered differences per window.
  for (genvar j = 0; j < SUMS; j++) begin : g_sum
    always_comb begin
      sumComb[j] = '0;
      for (int i = 0; i < GRP_BYTES; i++) begin
        sumComb[j] = sumComb[j] + WORD_BITS'(diffReg[j][i]);
      end
    end

    always_ff @(posedge clk) begin
      if (strobes.loadSum) sumReg[j] <= sumComb[j];
    end

    assign resultVec[j*WORD_BITS +: WORD_BITS] = sumReg[j];
  end
endmodule

// File: rtl/sad_multi_offset.sv
module sad_multi_offset
  import sad_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [VEC_W-1:0]  windowVec,
  input  logic [VEC_W-1:0]  refVec,
  input  logic [CTRL_W-1:0] ctrlByte,
  output logic              outValid,
  output logic [VEC_W-1:0]  resultVec
);
  ctrlStrobes_t strobes;

  sad_ctrl #(.CTRL_BITS(CTRL_W)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .ctrlByte (ctrlByte),
    .strobes  (strobes),
    .outValid (outValid)
  );

  sad_datapath #(
    .BYTE_BITS (BYTE_W),
    .GRP_BYTES (GROUP_BYTES),
    .SUMS      (NUM_SUMS),
    .WORD_BITS (SUM_W),
    .VEC_BITS  (VEC_W)
  ) i_datapath (
    .clk       (clk),
    .strobes   (strobes),
    .windowVec (windowVec),
    .refVec    (refVec),
    .resultVec (resultVec)
  );
endmodule

// File: rtl/sad_multi_offset_checker.sv
module sad_multi_offset_checker
  import sad_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             outValid,
  input logic [VEC_W-1:0] resultVec
);
  logic [1:0] sinceRst;
  logic       upperClear;
  logic       withinMax;

  always_ff @(posedge clk) begin
    if (rst) sinceRst <= '0;
    else if (sinceRst != 2'd2) sinceRst <= sinceRst + 2'd1;
  end

  always_comb begin
    upperClear = 1'b1;
    withinMax  = 1'b1;
    for (int j = 0; j < NUM_SUMS; j++) begin
      if (resultVec[j*SUM_W+10 +: SUM_W-10] != '0) upperClear = 1'b0;
      if (resultVec[j*SUM_W +: SUM_W] > SUM_W'(1020)) withinMax = 1'b0;
    end
  end

  a_r9_reset_clears: assert property (@(posedge clk) rst |=> !outValid);

  a_r8_two_cycle_latency: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd2) |-> (outValid == $past(inValid, 2)));

  a_r5_upper_bits_zero: assert property (@(posedge clk) disable iff (rst)
    outValid |-> upperClear);

  a_r5_sum_ceiling: assert property (@(posedge clk) disable iff (rst)
    outValid |-> withinMax);
endmodule

bind sad_multi_offset sad_multi_offset_checker i_chk (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .outValid  (outValid),
  .resultVec (resultVec)
);

// File: tb/test_sad_multi_offset.sv
module test_sad_multi_offset;
  logic         clk = 1'b0;
  logic         rst;
  logic         inValid;
  logic [127:0] windowVec;
  logic [127:0] refVec;
  logic [7:0]   ctrlByte;
  logic         outValid;
  logic [127:0] resultVec;

  int compared   = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  sad_multi_offset i_sad_multi_offset (
    .clk(clk), .rst(rst), .inValid(inValid), .windowVec(windowVec),
    .refVec(refVec), .ctrlByte(ctrlByte), .outValid(outValid),
    .resultVec(resultVec)
  );

  // Expected result written from the requirements (R1..R5).
  function automatic logic [127:0] model(input logic [127:0] w,
                                         input logic [127:0] r,
                                         input logic [7:0] c);
    logic [127:0] res;
    int k, b, acc, wb, rb;
    res = '0;
    k = int'(c[1:0]);
    b = c[2] ? 4 : 0;
    for (int j = 0; j < 8; j++) begin
      acc = 0;
      for (int i = 0; i < 4; i++) begin
        wb = int'(w[(b+j+i)*8 +: 8]);
        rb = int'(r[(4*k+i)*8 +: 8]);
        acc += (wb > rb) ? wb - rb : rb - wb;
      end
      res[j*16 +: 16] = 16'(acc);
    end
    return res;
  endfunction

  task automatic check(input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One operation: drive at a falling edge, sample two edges later.
  task automatic run_op(input string tag, input logic [127:0] w,
                        input logic [127:0] r, input logic [7:0] c,
                        output logic [127:0] got);
    @(negedge clk);
    windowVec = w; refVec = r; ctrlByte = c; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " valid low after one cycle"}, {127'd0, outValid}, 128'd0);
    @(negedge clk);
    check({tag, " valid after two cycles"}, {127'd0, outValid}, 128'd1);
    got = resultVec;
    @(negedge clk);
    check({tag, " valid single pulse"}, {127'd0, outValid}, 128'd0);
  endtask

  function automatic logic [127:0] pattern(input int seed);
    logic [127:0] v;
    for (int n = 0; n < 16; n++) v[n*8 +: 8] = 8'((n * 37 + seed * 91 + 13) ^ (seed * 7));
    return v;
  endfunction

  task automatic test_reset();
    rst = 1'b1; inValid = 1'b1; windowVec = '0; refVec = '0; ctrlByte = '0;
    repeat (3) @(negedge clk);
    check("R9 output valid low during reset", {127'd0, outValid}, 128'd0);
    inValid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R9 output valid low after reset", {127'd0, outValid}, 128'd0);
  endtask

  task automatic test_all_controls();
    logic [127:0] got, w, r;
    for (int seed = 1; seed <= 2; seed++) begin
      w = pattern(seed);
      r = pattern(seed + 5);
      for (int c = 0; c < 8; c++) begin
        run_op("R1 R2 R3 control sweep", w, r, 8'(c), got);
        check($sformatf("R1 R2 R3 ctrl=%0d seed=%0d", c, seed), got, model(w, r, 8'(c)));
      end
    end
  endtask

  task automatic test_distinct_sums();
    // Window byte n = n, reference group 2 all zero: sum j = 4(b+j)+6.
    logic [127:0] got, w, r, exp;
    for (int n = 0; n < 16; n++) w[n*8 +: 8] = 8'(n);
    r = {128{1'b1}};
    r[64 +: 32] = '0;
    run_op("R3 ramp", w, r, 8'h06, got);
    for (int j = 0; j < 8; j++) exp[j*16 +: 16] = 16'(4*(4+j)+6);
    check("R3 R5 sliding ramp, base 4, group 2", got, exp);
  endtask

  task automatic test_extremes();
    logic [127:0] got;
    run_op("R4 win high", {16{8'hFF}}, '0, 8'h00, got);
    check("R4 R5 window 255 vs reference 0 gives 1020", got, {8{16'd1020}});
    run_op("R4 ref high", '0, {16{8'hFF}}, 8'h07, got);
    check("R4 R5 window 0 vs reference 255 gives 1020", got, {8{16'd1020}});
    run_op("R4 equal", pattern(3), pattern(3), 8'h00, got);
    check("R4 equal operands", got, model(pattern(3), pattern(3), 8'h00));
  endtask

  task automatic test_ignored_bits();
    logic [127:0] gotA, gotB, w, r;
    w = pattern(4); r = pattern(9);
    for (int c = 0; c < 8; c++) begin
      run_op("R6 base", w, r, 8'(c), gotA);
      run_op("R6 high bits", w, r, 8'(c) | 8'hF8, gotB);
      check($sformatf("R6 upper control bits ignored ctrl=%0d", c), gotB, gotA);
    end
  endtask

  task automatic test_byte15();
    logic [127:0] gotA, gotB, w, r;
    w = pattern(6); r = pattern(2);
    for (int c = 0; c < 8; c++) begin
      w[120 +: 8] = 8'h00;
      run_op("R7 a", w, r, 8'(c), gotA);
      w[120 +: 8] = 8'hFF;
      run_op("R7 b", w, r, 8'(c), gotB);
      check($sformatf("R7 byte 15 ignored ctrl=%0d", c), gotB, gotA);
    end
  endtask

  task automatic test_back_to_back();
    logic [127:0] w [4];
    logic [127:0] r [4];
    logic [7:0]   c [4];
    for (int n = 0; n < 4; n++) begin
      w[n] = pattern(10 + n); r[n] = pattern(20 + n); c[n] = 8'(n * 3 + 1);
    end
    for (int cyc = 0; cyc < 6; cyc++) begin
      @(negedge clk);
      if (cyc >= 2) begin
        check($sformatf("R8 back-to-back valid op %0d", cyc - 2),
              {127'd0, outValid}, 128'd1);
        check($sformatf("R8 back-to-back result op %0d", cyc - 2),
              resultVec, model(w[cyc-2], r[cyc-2], c[cyc-2]));
      end
      if (cyc < 4) begin
        windowVec = w[cyc]; refVec = r[cyc]; ctrlByte = c[cyc]; inValid = 1'b1;
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    check("R8 valid drops after burst", {127'd0, outValid}, 128'd0);
  endtask

  task automatic test_reset_midflight();
    @(negedge clk);
    windowVec = pattern(1); refVec = pattern(2); ctrlByte = 8'h01; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R9 reset drops in-flight operation", {127'd0, outValid}, 128'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 no stale valid after reset", {127'd0, outValid}, 128'd0);
  endtask

  initial begin
    fork
      begin
        test_reset();
        test_all_controls();
        test_distinct_sums();
        test_extremes();
        test_ignored_bits();
        test_byte15();
        test_back_to_back();
        test_reset_midflight();
      end
      begin
        repeat (20000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule